// File: doc/BRIEF.md
# Indirect Flash Read Buffer Engine

This block fetches a programmed number of bytes from a flash device into an on-chip word buffer. An external master then empties the buffer with 32-bit reads. Software sets it up with a handful of register writes: the flash byte address, the byte count, a fill threshold and the base of a read window. It then writes a start bit. The fetch sequencer requests consecutive flash words over a simple request/response port and holds at most one request in flight. It stops while the buffer is full and continues as words are removed.

The master reads through a data port. Only reads whose address lies inside the programmed window take data from the buffer. A read in the window that finds the buffer empty during an operation is held off with a wait signal. A read outside the window returns zero and leaves the buffer untouched. When as many words have been drained as the byte count requires, the operation ends and a sticky completion flag rises. A watermark flag tells the master when enough words are waiting to make a burst of reads worthwhile.

Top module: `ird_engine`

## Requirements
- R1: After reset `busy`, `done`, `fl_req`, `ds_wait` and `wm_reached` (watermark reset value 1) are low.
- R2: The register offsets on `reg_addr` are: 0 = control (bit 0 starts), 1 = flash start address, 2 = byte count, 3 = watermark in words, 4 = window base. A start written while idle takes the start address with its two low bits cleared and takes the byte count. `busy` rises and `done` clears on the following edge.
- R3: For a count of n bytes the engine issues exactly ceil(n/4) flash requests, at the aligned start address plus 4*k for k = 0, 1, ... in order. It never has more than one request without a response. `fl_addr` holds steady while `fl_req` waits for `fl_ready`.
- R4: At most DEPTH fetched words are held. With no reads, fetching pauses after DEPTH requests and resumes as the master drains words.
- R5: A data read is in the window when `ds_addr` bits above WIN_LOG2 equal the same bits of the window base. An in-window read with a buffered word returns the oldest word and removes it, so words arrive in flash address order.
- R6: An in-window read while busy with an empty buffer raises `ds_wait` until a word arrives.
- R7: A read outside the window returns zero without wait and removes nothing.
- R8: When ceil(n/4) words have been drained, `busy` falls and `done` rises on the next edge. `done` stays high until the next start. A count of 0 finishes one cycle after the start.
- R9: `wm_reached` is high exactly when the buffered word count is at or above the watermark.
- R10: A start written while busy is ignored, and the operation keeps its original address and count.
- R11: An in-window read while idle with an empty buffer returns zero without wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| fl_req | output | 1 | Flash word request |
| fl_addr | output | FA_W | Flash byte address of the request |
| fl_ready | input | 1 | Flash accepts the request |
| fl_rvalid | input | 1 | Flash response valid |
| fl_rdata | input | 32 | Flash response word |
| ds_rd | input | 1 | Data-port read, held while `ds_wait` |
| ds_addr | input | DS_AW | Data-port byte address |
| ds_rdata | output | 32 | Data-port read word |
| ds_wait | output | 1 | Data-port read stalled |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Sticky completion flag |
| wm_reached | output | 1 | Buffer fill at or above watermark |

## Verification
The assertions assume the flash side sends exactly one `fl_rvalid` for each accepted request and never sends one unprompted. They also assume the master holds `ds_rd` and `ds_addr` steady while `ds_wait` is high. The bench's flash model answers each accepted request once, after a fixed latency, with an address-derived word, and it throttles `fl_ready` in a repeating pattern. The bench's read task keeps the request up until the wait clears. Register writes come one per two cycles and never collide with a read-dependent decision.

// File: rtl/ird_pkg.sv
package ird_pkg;
   typedef enum logic [2:0] {
      REG_CTRL  = 3'd0,
      REG_SADDR = 3'd1,
      REG_COUNT = 3'd2,
      REG_WMARK = 3'd3,
      REG_TRIG  = 3'd4
   } ird_reg_e;

   localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/ird_regs.sv
module ird_regs #(
   parameter int unsigned FA_W   = 24,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned FILL_W = 5,
   parameter int unsigned DS_AW  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              finish,
   output logic              start,
   output logic              busy,
   output logic              done,
   output logic [FA_W-1:0]   op_addr,
   output logic [CNT_W-1:0]  op_words,
   output logic [FILL_W-1:0] wmark,
   output logic [DS_AW-1:0]  trig
);
   import ird_pkg::*;

   logic [FA_W-1:0]  saddr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   words_nx;

   assign start    = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[0] && !busy;
   assign words_nx = ({1'b0, cnt_q} + (CNT_W+1)'(3)) >> 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         saddr_q  <= '0;
         cnt_q    <= '0;
         wmark    <= FILL_W'(1);
         trig     <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
         op_addr  <= '0;
         op_words <= '0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               REG_SADDR: saddr_q <= reg_wdata[FA_W-1:0];
               REG_COUNT: cnt_q   <= reg_wdata[CNT_W-1:0];
               REG_WMARK: wmark   <= reg_wdata[FILL_W-1:0];
               REG_TRIG:  trig    <= reg_wdata[DS_AW-1:0];
               default: ;
            endcase
         end
         if (start) begin
            busy     <= 1'b1;
            done     <= 1'b0;
            op_addr  <= {saddr_q[FA_W-1:2], 2'b00};
            op_words <= words_nx[CNT_W-1:0];
         end else if (finish) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end

   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !finish && reg_wr && (reg_addr == REG_CTRL) && reg_wdata[0]
      |=> busy && $stable(op_words) && $stable(op_addr));

   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

   a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy && !done);
endmodule

// File: rtl/ird_fetch.sv
module ird_fetch #(
   parameter int unsigned FA_W  = 24,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             busy,
   input  logic [FA_W-1:0]  op_addr,
   input  logic [CNT_W-1:0] op_words,
   input  logic             full,
   input  logic             fl_ready,
   input  logic             fl_rvalid,
   output logic             fl_req,
   output logic [FA_W-1:0]  fl_addr,
   output logic             push
);
   logic [CNT_W-1:0] issued;
   logic             pend;

   assign fl_req  = busy && !pend && (issued != op_words) && !full;
   assign fl_addr = op_addr + (FA_W'(issued) << 2);
   assign push    = fl_rvalid && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issued <= '0;
         pend   <= 1'b0;
      end else if (start) begin
         issued <= '0;
         pend   <= 1'b0;
      end else if (fl_req && fl_ready) begin
         issued <= issued + 1'b1;
         pend   <= 1'b1;
      end else if (push) begin
         pend <= 1'b0;
      end
   end

   a_r3_resp_expected: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rvalid |-> pend);

   a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && !fl_ready |=> fl_req && $stable(fl_addr));
endmodule

// File: rtl/ird_fifo.sv
module ird_fifo #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned W      = 32,
   parameter int unsigned FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [W-1:0]      wdata,
   input  logic              pop,
   output logic [W-1:0]      rdata,
   output logic              empty,
   output logic              full,
   output logic [FILL_W-1:0] fill
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_nx, rp_nx;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign empty = (fill == '0);
   assign full  = (fill == FILL_W'(DEPTH));
   assign rdata = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         if (push && !pop)      fill <= fill + 1'b1;
         else if (pop && !push) fill <= fill - 1'b1;
      end
   end

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

   a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_W'(DEPTH));
endmodule

// File: rtl/ird_drain.sv
module ird_drain #(
   parameter int unsigned DS_AW    = 16,
   parameter int unsigned WIN_LOG2 = 6,
   parameter int unsigned CNT_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             busy,
   input  logic [CNT_W-1:0] op_words,
   input  logic [DS_AW-1:0] trig,
   input  logic             ds_rd,
   input  logic [DS_AW-1:0] ds_addr,
   input  logic             empty,
   input  logic [31:0]      head,
   output logic [31:0]      ds_rdata,
   output logic             ds_wait,
   output logic             pop,
   output logic             finish
);
   logic             in_win;
   logic [CNT_W-1:0] drained;

   assign in_win   = (ds_addr[DS_AW-1:WIN_LOG2] == trig[DS_AW-1:WIN_LOG2]);
   assign pop      = ds_rd && in_win && !empty;
   assign ds_wait  = ds_rd && in_win && empty && busy;
   assign ds_rdata = pop ? head : '0;
   assign finish   = busy && (drained == op_words);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     drained <= '0;
      else if (start) drained <= '0;
      else if (pop)   drained <= drained + 1'b1;
   end

   a_r6_wait_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      ds_wait |-> !pop && (ds_rdata == '0));

   a_r8_no_overdrain: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> drained <= op_words);
endmodule

// File: rtl/ird_engine.sv
module ird_engine #(
   parameter int unsigned FA_W     = 24,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned DS_AW    = 16,
   parameter int unsigned WIN_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic             fl_req,
   output logic [FA_W-1:0]  fl_addr,
   input  logic             fl_ready,
   input  logic             fl_rvalid,
   input  logic [31:0]      fl_rdata,
   input  logic             ds_rd,
   input  logic [DS_AW-1:0] ds_addr,
   output logic [31:0]      ds_rdata,
   output logic             ds_wait,
   output logic             busy,
   output logic             done,
   output logic             wm_reached
);
   localparam int unsigned FILL_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (FA_W < 3 || FA_W > 32) begin : g_bad_fa
         $error("FA_W must lie in 3..32");
      end
      if (CNT_W < 3 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 3..32");
      end
      if (WIN_LOG2 < 2 || WIN_LOG2 >= DS_AW || DS_AW > 32) begin : g_bad_win
         $error("WIN_LOG2 must lie in 2..DS_AW-1 and DS_AW at most 32");
      end
   endgenerate

   logic              start, finish, push, pop, empty, full;
   logic [FA_W-1:0]   op_addr;
   logic [CNT_W-1:0]  op_words;
   logic [FILL_W-1:0] wmark, fill;
   logic [DS_AW-1:0]  trig;
   logic [31:0]       head;

   ird_regs #(.FA_W(FA_W), .CNT_W(CNT_W), .FILL_W(FILL_W), .DS_AW(DS_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .finish(finish), .start(start), .busy(busy),
      .done(done), .op_addr(op_addr), .op_words(op_words), .wmark(wmark),
      .trig(trig));

   ird_fetch #(.FA_W(FA_W), .CNT_W(CNT_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .op_addr(op_addr),
      .op_words(op_words), .full(full), .fl_ready(fl_ready),
      .fl_rvalid(fl_rvalid), .fl_req(fl_req), .fl_addr(fl_addr), .push(push));

   ird_fifo #(.DEPTH(DEPTH), .W(32), .FILL_W(FILL_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(fl_rdata), .pop(pop),
      .rdata(head), .empty(empty), .full(full), .fill(fill));

   ird_drain #(.DS_AW(DS_AW), .WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_drain (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .op_words(op_words),
      .trig(trig), .ds_rd(ds_rd), .ds_addr(ds_addr), .empty(empty),
      .head(head), .ds_rdata(ds_rdata), .ds_wait(ds_wait), .pop(pop),
      .finish(finish));

   assign wm_reached = (fill >= wmark);

   a_r8_finish_done: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> !busy && done);

   a_r8_idle_drained: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> empty && !fl_req);
endmodule

// File: tb/tb_ird_engine.sv
module tb_ird_engine;
   localparam int unsigned FA_W = 24, CNT_W = 8, DEPTH = 4, DS_AW = 12, WIN_LOG2 = 6;
   localparam logic [DS_AW-1:0] TRIG = 12'h340;

   logic             clk = 1'b0, rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [2:0]       reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic             fl_req, fl_ready = 1'b0, fl_rvalid = 1'b0;
   logic [FA_W-1:0]  fl_addr;
   logic [31:0]      fl_rdata = '0;
   logic             ds_rd = 1'b0;
   logic [DS_AW-1:0] ds_addr = '0;
   logic [31:0]      ds_rdata;
   logic             ds_wait, busy, done, wm_reached;

   int checks = 0, failures = 0;
   int issued = 0;
   logic [FA_W-1:0] exp_fa = '0;

   ird_engine #(.FA_W(FA_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .DS_AW(DS_AW),
                .WIN_LOG2(WIN_LOG2)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .fl_req(fl_req), .fl_addr(fl_addr),
      .fl_ready(fl_ready), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata),
      .ds_rd(ds_rd), .ds_addr(ds_addr), .ds_rdata(ds_rdata), .ds_wait(ds_wait),
      .busy(busy), .done(done), .wm_reached(wm_reached));

   always #10 clk = ~clk;

   function automatic logic [31:0] fdata(input logic [FA_W-1:0] a);
      return {8'hC3, a} ^ {a[16:0], 15'h0};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // flash responder: fixed two-cycle latency, throttled ready
   initial begin : flash_model
      logic            d1_v, d2_v, prev_wait;
      logic [FA_W-1:0] d1_a, d2_a, prev_a;
      int tick;
      d1_v = 0; d2_v = 0; prev_wait = 0; d1_a = '0; d2_a = '0; prev_a = '0; tick = 0;
      forever begin
         @(negedge clk);
         fl_rvalid = d2_v;
         fl_rdata  = fdata(d2_a);
         d2_v = d1_v; d2_a = d1_a; d1_v = 0;
         fl_ready = (tick % 3) != 2;
         tick++;
         #1;
         if (prev_wait)
            check(fl_req && fl_addr == prev_a, "R3 addr hold", fl_addr, prev_a);
         if (fl_req && fl_ready) begin
            check(fl_addr == exp_fa, "R3 request address", fl_addr, exp_fa);
            check(!d2_v && !fl_rvalid, "R3 single outstanding", d2_v, 0);
            exp_fa = exp_fa + 4;
            issued++;
            d1_v = 1; d1_a = fl_addr;
         end
         prev_wait = fl_req && !fl_ready;
         prev_a    = fl_addr;
      end
   end

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic ds_read(input logic [DS_AW-1:0] a, output logic [31:0] d,
                          output bit waited);
      @(negedge clk);
      ds_rd = 1'b1; ds_addr = a; waited = 0;
      #2;
      while (ds_wait) begin
         waited = 1;
         @(negedge clk);
         #2;
      end
      d = ds_rdata;
      @(posedge clk);
      #1 ds_rd = 1'b0;
   endtask

   task automatic arm(input logic [FA_W-1:0] sa, input int nbytes);
      exp_fa = {sa[FA_W-1:2], 2'b00};
      issued = 0;
      reg_write(3'd1, 32'(sa));
      reg_write(3'd2, 32'(nbytes));
      reg_write(3'd0, 32'h1);
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      check(done == 1'b0, "R2 done cleared", done, 0);
   endtask

   task automatic drain_check(input logic [FA_W-1:0] sa, input int nw, input int gap,
                              input bit expect_wait_first, input int busy_probe);
      logic [31:0] d;
      bit w;
      logic [FA_W-1:0] base;
      base = {sa[FA_W-1:2], 2'b00};
      for (int k = 0; k < nw; k++) begin
         repeat (gap) @(negedge clk);
         if (k == busy_probe) check(busy == 1'b1, "R10 still busy", busy, 1);
         ds_read(TRIG + DS_AW'(4 * (k % 16)), d, w);
         check(d == fdata(base + FA_W'(4 * k)), "R5 word order", d,
               fdata(base + FA_W'(4 * k)));
         if (k == 0 && expect_wait_first)
            check(w == 1'b1, "R6 wait on empty", w, 1);
      end
      @(negedge clk);
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b1, "R8 finish", {busy, done}, 2'b01);
      check(issued == nw, "R3 request count", issued, nw);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      bit w;
      logic [FA_W-1:0] starts [3];
      starts[0] = 24'h000000; starts[1] = 24'h012346; starts[2] = 24'hFFFFF8;

      repeat (3) @(negedge clk);
      check(!busy && !done && !fl_req && !ds_wait && !wm_reached, "R1 reset state",
            {busy, done, fl_req, ds_wait, wm_reached}, 0);
      rst_n = 1'b1;
      reg_write(3'd4, 32'(TRIG));

      // R11: idle in-window read with empty buffer
      ds_read(TRIG, d, w);
      check(d == 0 && !w, "R11 idle read", d, 0);

      // sweep: byte counts, start addresses, drain gaps
      for (int n = 0; n < 14; n++)
         for (int s = 0; s < 3; s++)
            for (int g = 0; g < 3; g++) begin
               arm(starts[s], n);
               if (n == 0) begin
                  @(negedge clk); @(negedge clk);
                  check(!busy && done, "R8 zero count", {busy, done}, 2'b01);
                  check(issued == 0, "R3 zero count requests", issued, 0);
               end else
                  drain_check(starts[s], (n + 3) / 4, g, g == 0, -1);
            end

      // buffer full, watermark sweep, outside reads, start while busy
      arm(24'h000400, 40);
      repeat (30) @(negedge clk);
      check(issued == DEPTH, "R4 fetch pauses when full", issued, DEPTH);
      for (int wm = 0; wm <= DEPTH + 1; wm++) begin
         reg_write(3'd3, 32'(wm));
         check(wm_reached == (DEPTH >= wm), "R9 watermark", wm_reached, DEPTH >= wm);
      end
      reg_write(3'd3, 32'(DEPTH));
      ds_read(TRIG + 12'h040, d, w);
      check(d == 0 && !w, "R7 above window", d, 0);
      ds_read(TRIG - 12'h004, d, w);
      check(d == 0 && !w, "R7 below window", d, 0);
      @(negedge clk);
      check(wm_reached == 1'b1, "R7 no pop outside", wm_reached, 1);
      reg_write(3'd2, 32'd4);
      reg_write(3'd1, 32'h8000);
      reg_write(3'd0, 32'h1);
      check(busy == 1'b1, "R10 start ignored", busy, 1);
      drain_check(24'h000400, 10, 1, 1'b0, 9);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule